// File: doc/BRIEF.md
# Multi-Mode Watchdog Interval Timer

This block is an overflow timer driven by a prescaled tick from an external clock-select stage. An 8-bit control register sits on the bus. Software uses it to start the counter and to choose what an overflow does. The choices are a maskable interrupt (the request flag is set), a non-maskable interrupt pulse, or a one-cycle system reset request. The register takes whole-byte writes and single-bit writes.

The run bit and the two mode bits can only be set. A write of 0 leaves them as they are, and only the block reset returns them to 0. A write that sets the run bit clears the main counter. It does not touch the prescaler, so the first interval after such a restart can be up to one tick period short. The interrupt controller is represented only by a request flag output and a dedicated clear input. If that flag is already pending at the moment software enters a watchdog mode, a non-maskable interrupt fires at once.

Top module: `guardTimer`

## Requirements
- R1: After reset, rdData reads 8'h00, and irqFlag, nmiReq and rstReq are 0.
- R2: rdData shows the run bit at bit 7 and the mode bits at bits 4 and 3. All other bits read 0. Mode encoding {bit4,bit3}: 00 stopped (acts as interval), 01 interval, 10 watchdog with NMI, 11 watchdog with reset.
- R3: Once the run bit is 1, no write can clear it. Every write that carries run=1 clears the counter, including a write made while the counter is already running.
- R4: Once a mode bit (bit 4 or bit 3) is 1, no write can clear it.
- R5: With wrBitMode=0 a write applies all of wrData. With wrBitMode=1 only the bit at index wrBitSel is written, and its value is taken from wrData[0].
- R6: While running, the 8-bit counter advances once per cycle in which tick is high. An overflow happens on the 256th tick after a clear. If a write carrying run=1 falls in the same cycle as the wrapping tick, the clear wins and no overflow occurs.
- R7: An overflow sets irqFlag from the next cycle on. flagClr clears irqFlag. When an overflow and flagClr fall in the same cycle, the overflow wins.
- R8: In mode 10, an overflow gives a one-cycle nmiReq pulse in the next cycle.
- R9: In mode 11, an overflow gives a one-cycle rstReq pulse in the next cycle.
- R10: With bit 4 at 0, an overflow gives neither nmiReq nor rstReq.
- R11: A write that raises bit 4 from 0 to 1 while irqFlag is 1 gives an nmiReq pulse in the next cycle.
- R12: While the run bit is 0, ticks never cause an overflow, whatever the mode bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrBitMode | input | 1 | 1: single-bit write, 0: byte write |
| wrBitSel | input | 3 | Bit index used in single-bit writes |
| wrData | input | 8 | Write data (bit 0 is the bit value in single-bit writes) |
| tick | input | 1 | Prescaled count enable from the clock-select stage |
| flagClr | input | 1 | Clears the interrupt request flag |
| rdData | output | 8 | Control register readback |
| irqFlag | output | 1 | Interrupt request flag |
| nmiReq | output | 1 | Non-maskable interrupt pulse |
| rstReq | output | 1 | System reset request pulse |

## Verification
Three collisions can fall in a single cycle. A restart write can meet the wrapping tick. A flag clear can meet an overflow. A mode write that raises bit 4 can meet a still-pending flag. Directed sequences line up each collision exactly: 255 ticks are counted, and the restart write, flagClr or the mode write is then placed on the cycle that counts. The result is judged by whether irqFlag and nmiReq appear in the following cycle. Long random runs are compared cycle by cycle with a bench model derived from the requirements, and they hit the same collisions by chance.

// File: rtl/gtPkg.sv
package gtPkg;
  localparam int REG_W   = 8;
  localparam int RUN_BIT = 7;
  localparam int MHI_BIT = 4;
  localparam int MLO_BIT = 3;
  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << RUN_BIT) | (REG_W'(1) << MHI_BIT) | (REG_W'(1) << MLO_BIT);

  // strobes from control to the counting datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } cntCmd_t;
endpackage

// File: rtl/gtCount.sv
module gtCount
  import gtPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    cntFull
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.clear)   cnt <= '0;
    else if (cmd.advance) cnt <= cnt + 1'b1;
  end

  assign cntFull = (cnt == CNT_TOP);

  // R3: a restart write leaves the counter at zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> cnt == '0);
  // R6: one step per tick
  a_r6_one_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advance && !cmd.clear) |=> cnt == $past(cnt) + 1'b1);
  // R12: nothing moves without an advance or clear
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.advance && !cmd.clear) |=> $stable(cnt));
endmodule

// File: rtl/gtCtrl.sv
module gtCtrl
  import gtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrBitMode,
  input  logic [2:0]       wrBitSel,
  input  logic [REG_W-1:0] wrData,
  input  logic             tick,
  input  logic             flagClr,
  input  logic             cntFull,
  output cntCmd_t          cmd,
  output logic [REG_W-1:0] rdData,
  output logic             irqFlag,
  output logic             nmiReq,
  output logic             rstReq
);
  logic             runBit, modeHi, modeLo;
  logic [REG_W-1:0] rawSet, setMask;
  logic             ovf, enterWatch;

  // only ones are ever stored: a write reduces to a set mask
  always_comb begin
    if (!wrEn)          rawSet = '0;
    else if (wrBitMode) rawSet = wrData[0] ? (REG_W'(1) << wrBitSel) : '0;
    else                rawSet = wrData;
    setMask = rawSet & LIVE_MASK;
  end

  assign cmd.clear   = setMask[RUN_BIT];
  assign cmd.advance = runBit && tick;
  assign ovf         = cmd.advance && cntFull && !cmd.clear;
  assign enterWatch  = setMask[MHI_BIT] && !modeHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      modeHi  <= 1'b0;
      modeLo  <= 1'b0;
      irqFlag <= 1'b0;
      nmiReq  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      runBit  <= runBit | setMask[RUN_BIT];
      modeHi  <= modeHi | setMask[MHI_BIT];
      modeLo  <= modeLo | setMask[MLO_BIT];
      if (ovf)          irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;
      nmiReq  <= (ovf && modeHi && !modeLo) || (enterWatch && irqFlag);
      rstReq  <= ovf && modeHi && modeLo;
    end
  end

  always_comb begin
    rdData          = '0;
    rdData[RUN_BIT] = runBit;
    rdData[MHI_BIT] = modeHi;
    rdData[MLO_BIT] = modeLo;
  end

  a_r3_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    runBit |=> runBit);
  a_r4_hi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeHi |=> modeHi);
  a_r4_lo_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeLo |=> modeLo);
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> irqFlag);
  a_r9_rst_single: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nmiReq, rstReq}));
  a_r10_interval_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !modeHi && !setMask[MHI_BIT]) |=> (!nmiReq && !rstReq));
  a_r11_pending_nmi: assert property (@(posedge clk) disable iff (!rstN)
    (enterWatch && irqFlag) |=> nmiReq);
  a_r12_no_ovf_idle: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !ovf);
endmodule

// File: rtl/guardTimer.sv
module guardTimer
  import gtPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrBitMode,
  input  logic [2:0] wrBitSel,
  input  logic [7:0] wrData,
  input  logic       tick,
  input  logic       flagClr,
  output logic [7:0] rdData,
  output logic       irqFlag,
  output logic       nmiReq,
  output logic       rstReq
);
  cntCmd_t cmd;
  logic    cntFull;

  gtCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBitMode(wrBitMode),
    .wrBitSel(wrBitSel), .wrData(wrData), .tick(tick), .flagClr(flagClr),
    .cntFull(cntFull), .cmd(cmd), .rdData(rdData), .irqFlag(irqFlag),
    .nmiReq(nmiReq), .rstReq(rstReq)
  );

  gtCount #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntFull(cntFull)
  );
endmodule

// File: tb/test_guardTimer.sv
`timescale 1ns/1ps
module test_guardTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, wrBitMode = 1'b0, tick = 1'b0, flagClr = 1'b0;
  logic [2:0] wrBitSel = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqFlag, nmiReq, rstReq;

  int nVec = 0, nBad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] mReg;
  int         mCnt;
  logic       mFlag, mNmi, mRst;

  always #2.5 clk = ~clk;

  guardTimer i_guardTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBitMode(wrBitMode),
    .wrBitSel(wrBitSel), .wrData(wrData), .tick(tick), .flagClr(flagClr),
    .rdData(rdData), .irqFlag(irqFlag), .nmiReq(nmiReq), .rstReq(rstReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] setOf(input logic we, input logic bm,
                                       input logic [2:0] sel, input logic [7:0] d);
    logic [7:0] m;
    if (!we)     m = 8'h00;
    else if (bm) m = d[0] ? (8'h01 << sel) : 8'h00;
    else         m = d;
    return m & 8'h98;
  endfunction

  // one cycle: drive at negedge, model next state, compare at next negedge
  task automatic step(input logic we, input logic bm, input logic [2:0] sel,
                      input logic [7:0] d, input logic tk, input logic clr);
    logic [7:0] s;
    logic adv, ovf;
    wrEn = we; wrBitMode = bm; wrBitSel = sel; wrData = d; tick = tk; flagClr = clr;
    s   = setOf(we, bm, sel, d);
    adv = mReg[7] && tk;
    ovf = adv && (mCnt == 255) && !s[7];
    mNmi = (ovf && mReg[4] && !mReg[3]) || (s[4] && !mReg[4] && mFlag);
    mRst = ovf && mReg[4] && mReg[3];
    if (ovf) mFlag = 1'b1; else if (clr) mFlag = 1'b0;
    if (s[7]) mCnt = 0; else if (adv) mCnt = (mCnt + 1) % 256;
    mReg = mReg | s;
    @(negedge clk);
    check("R2 rdData", rdData, mReg);
    check("R7 irqFlag", {7'd0, irqFlag}, {7'd0, mFlag});
    check("R8 nmiReq", {7'd0, nmiReq}, {7'd0, mNmi});
    check("R9 rstReq", {7'd0, rstReq}, {7'd0, mRst});
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; tick = 1'b0; flagClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mReg = 8'h00; mCnt = 0; mFlag = 1'b0; mNmi = 1'b0; mRst = 1'b0;
    check("R1 reset rdData", rdData, 8'h00);
    check("R1 reset outputs", {5'd0, irqFlag, nmiReq, rstReq}, 8'h00);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    // first sequence: mode 10 set before run, then single-bit run write
    doReset();
    step(1'b1, 1'b0, 3'd0, 8'h10, 1'b0, 1'b0);
    idleTicks(300);
    check("R12 no overflow while stopped", {7'd0, irqFlag}, 8'h00);
    check("R2 mode readback", rdData, 8'h10);
    step(1'b1, 1'b1, 3'd7, 8'h01, 1'b0, 1'b0);
    check("R5 bit write sets run", rdData, 8'h90);
    step(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    check("R3 R4 zero write ignored", rdData, 8'h90);
    step(1'b1, 1'b1, 3'd4, 8'hFE, 1'b0, 1'b0);
    check("R5 bit value from wrData[0]", rdData, 8'h90);
    idleTicks(255);
    check("R6 no overflow at 255 ticks", {7'd0, irqFlag}, 8'h00);
    idleTicks(1);
    check("R8 nmi on overflow", {6'd0, nmiReq, irqFlag}, 8'h03);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    check("R8 nmi single cycle", {7'd0, nmiReq}, 8'h00);

    // second sequence: collisions
    doReset();
    step(1'b1, 1'b0, 3'd0, 8'h80, 1'b0, 1'b0);
    idleTicks(255);
    step(1'b1, 1'b0, 3'd0, 8'h80, 1'b1, 1'b0);
    check("R6 restart beats wrap", {7'd0, irqFlag}, 8'h00);
    idleTicks(255);
    check("R3 restart cleared counter", {7'd0, irqFlag}, 8'h00);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1);
    check("R7 overflow beats clear", {7'd0, irqFlag}, 8'h01);
    check("R10 interval quiet", {6'd0, nmiReq, rstReq}, 8'h00);
    step(1'b1, 1'b1, 3'd4, 8'h01, 1'b0, 1'b0);
    check("R11 pending flag nmi", {7'd0, nmiReq}, 8'h01);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    check("R7 flag cleared", {7'd0, irqFlag}, 8'h00);
    step(1'b1, 1'b1, 3'd3, 8'h01, 1'b0, 1'b0);
    check("R4 R5 mode 11 readback", rdData, 8'h98);
    idleTicks(256);
    check("R9 reset request", {7'd0, rstReq}, 8'h01);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    check("R9 reset single cycle", {7'd0, rstReq}, 8'h00);

    // random episodes against the model
    for (int e = 0; e < 24; e++) begin
      doReset();
      for (int c = 0; c < 1200; c++) begin
        logic we;
        we = ($urandom % 40) == 0;
        step(we, $urandom % 2, 3'($urandom), 8'($urandom),
             ($urandom % 4) != 0, ($urandom % 30) == 0);
      end
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule